// File: doc/BRIEF.md
# Addressed Three-Wire Configuration Register Slave

This block is a write-only serial configuration slave. An external controller drives three pins: a serial clock, a serial data line and an active-low frame enable. While the enable is low, each rising edge of the serial clock shifts one data bit into a 16-bit frame, most significant bit first. When the enable returns high, the frame is committed to one of four 14-bit registers. The two least significant bits of the frame select the register. The upper fourteen bits of the frame are the payload that is stored.

All three pins are resampled by a faster system clock, so every register update happens in the system clock domain. The registers are decoded into parallel fields for downstream logic:

- a 28-bit fractional divide word, split across two addresses;
- an integer divide value;
- a reference-divider code;
- a charge-pump level code and a bleed code;
- a reset-delay code;
- six test bits and six control bits.

The two fraction halves are also presented as one 28-bit word. This word changes only when the lower half is written, so downstream logic never sees a mix of an old half and a new half.

Top module: `serial_cfg_slave`

## Requirements
- R1: After reset, the outputs hold these values: frac_hi=8192, frac_lo=0, frac_word=8192*16384, ref_code=0, bleed_code=0, cp_level=3, n_div=177, rst_dly=0, test_bits=0, ctrl_bits=15. In ctrl_bits, bit 5 is the modulator bypass, bit 4 the power-down enable, bit 3 the transmit enable, bit 2 the buffer enable, bit 1 is unused and bit 0 is the current doubler.
- R2: A data bit is captured only on a rising edge of ser_clk that occurs while ser_en_n is low. Bits enter most significant bit first. Edges of ser_clk while ser_en_n is high neither shift data nor count bits.
- R3: On a rising edge of ser_en_n, a frame of exactly 16 captured bits is committed. Frame bits [1:0] give the address and frame bits [15:2] give the 14-bit payload.
- R4: Address 0 loads frac_hi, which holds fraction bits 27..14. Address 1 loads frac_lo, which holds fraction bits 13..0.
- R5: Address 2 fills fields from the payload: ref_code from payload [13:12], bleed_code from [11:10], cp_level from [9:8] and n_div from [7:0].
- R6: Address 3 fills fields from the payload: rst_dly from payload [13:12], test_bits from [11:6] and ctrl_bits from [5:0].
- R7: If ser_en_n rises after any number of captured bits other than 16, whether fewer or more, every register is left unchanged.
- R8: frac_word changes only on a committed write to address 1. It then becomes {frac_hi, new lower payload}. A write to address 0 alone leaves frac_word unchanged.
- R9: All three pins pass through SYNC_STAGES resampling flops. Take the system clock edge at which the ser_en_n rise is first sampled as edge k. The commit becomes visible after edge k+SYNC_STAGES, and the outputs are unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is captured on its rising edges |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| frac_word | output | 28 | Atomic fractional divide word |
| frac_hi | output | 14 | Upper fraction register (address 0) |
| frac_lo | output | 14 | Lower fraction register (address 1) |
| ref_code | output | 2 | Reference divider code |
| bleed_code | output | 2 | Charge-pump bleed code |
| cp_level | output | 2 | Charge-pump current code |
| n_div | output | 8 | Integer divide value |
| rst_dly | output | 2 | Reset delay code |
| test_bits | output | 6 | Test bits |
| ctrl_bits | output | 6 | Control bits (bit order as in R1) |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default of 2. This exercises a deeper resampling chain and lets the bench confirm that the commit latency follows the parameter rather than a fixed count. A behavioural model delays the sampled pins by the same depth and is compared against every output on each clock. Directed frames cover all four addresses, short and long frames, clock pulses sent while the enable is high, and the hold of the fraction word between the writes to its two halves.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

  // Frame geometry
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 2;
  localparam int PAY_W      = FRAME_BITS - ADDR_W;
  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int FRAC_W     = 2 * PAY_W;

  // Field widths
  localparam int CODE_W = 2;
  localparam int NDIV_W = 8;
  localparam int TEST_W = 6;
  localparam int CTRL_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FRAC_HI = 2'd0,
    ADR_FRAC_LO = 2'd1,
    ADR_DIVIDE  = 2'd2,
    ADR_CONFIG  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [CODE_W-1:0] ref_code;
    logic [CODE_W-1:0] bleed;
    logic [CODE_W-1:0] cp;
    logic [NDIV_W-1:0] n;
  } divide_t;

  typedef struct packed {
    logic [CODE_W-1:0] dly;
    logic [TEST_W-1:0] test;
    logic [CTRL_W-1:0] ctrl;
  } config_t;

  localparam logic [PAY_W-1:0] DEF_FRAC_HI = PAY_W'(8192);
  localparam logic [PAY_W-1:0] DEF_FRAC_LO = '0;
  localparam divide_t DEF_DIVIDE = '{ref_code: 2'd0, bleed: 2'd0, cp: 2'd3, n: 8'd177};
  localparam config_t DEF_CONFIG = '{dly: 2'd0, test: 6'd0, ctrl: 6'd15};

  function automatic logic [PAY_W-1:0] reg_default(input logic [ADDR_W-1:0] a);
    case (a)
      ADR_FRAC_HI: return DEF_FRAC_HI;
      ADR_FRAC_LO: return DEF_FRAC_LO;
      ADR_DIVIDE:  return DEF_DIVIDE;
      default:     return DEF_CONFIG;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_BITS-1:0] f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic logic [PAY_W-1:0] frame_payload(input logic [FRAME_BITS-1:0] f);
    return f[FRAME_BITS-1:ADDR_W];
  endfunction

  function automatic logic [FRAC_W-1:0] join_fraction(input logic [PAY_W-1:0] hi,
                                                      input logic [PAY_W-1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int                STAGES  = 2,
  parameter int                WIDTH   = 1,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cfg3w_frame.sv
module cfg3w_frame
  import cfg3w_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_clk,
  input  logic                  s_dat,
  input  logic                  s_en_n,
  output logic                  clk_rise,
  output logic                  wr_fire,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [PAY_W-1:0]      wr_payload,
  output logic [FRAME_BITS-1:0] sh_word,
  output logic [CNT_W-1:0]      bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

  logic clk_d;
  logic en_d;
  logic en_rise;
  logic frame_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      en_d  <= 1'b1;
    end else begin
      clk_d <= s_clk;
      en_d  <= s_en_n;
    end
  end

  assign clk_rise = s_clk & ~clk_d;
  assign en_rise  = s_en_n & ~en_d;

  // Shift only inside a frame; the count saturates one past a full frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_word <= '0;
      bit_cnt <= '0;
    end else if (s_en_n) begin
      bit_cnt <= '0;
    end else if (clk_rise) begin
      sh_word <= {sh_word[FRAME_BITS-2:0], s_dat};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + CNT_W'(1);
    end
  end

  assign frame_full = (bit_cnt == CNT_FULL);
  assign wr_fire    = en_rise & frame_full;
  assign wr_addr    = frame_addr(sh_word);
  assign wr_payload = frame_payload(sh_word);

endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PAY_W-1:0]  wr_payload,
  output logic [PAY_W-1:0]  bank_hi,
  output logic [PAY_W-1:0]  bank_lo,
  output logic [PAY_W-1:0]  bank_div,
  output logic [PAY_W-1:0]  bank_cfg,
  output logic [FRAC_W-1:0] frac_q
);

  logic [NUM_REGS-1:0][PAY_W-1:0] bank;

  for (genvar a = 0; a < NUM_REGS; a++) begin : g_reg
    logic [PAY_W-1:0] q;
    logic             hit;
    assign hit = wr_fire && (wr_addr == ADDR_W'(a));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= reg_default(ADDR_W'(a));
      else if (hit) q <= wr_payload;
    end
    assign bank[a] = q;
  end

  assign bank_hi  = bank[ADR_FRAC_HI];
  assign bank_lo  = bank[ADR_FRAC_LO];
  assign bank_div = bank[ADR_DIVIDE];
  assign bank_cfg = bank[ADR_CONFIG];

  // Joined fraction: refreshed only when the lower half lands.
  logic lo_hit;
  assign lo_hit = wr_fire && (wr_addr == ADR_FRAC_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frac_q <= join_fraction(DEF_FRAC_HI, DEF_FRAC_LO);
    else if (lo_hit) frac_q <= join_fraction(bank_hi, wr_payload);
  end

endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave
  import cfg3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en_n,
  output logic [FRAC_W-1:0] frac_word,
  output logic [PAY_W-1:0]  frac_hi,
  output logic [PAY_W-1:0]  frac_lo,
  output logic [CODE_W-1:0] ref_code,
  output logic [CODE_W-1:0] bleed_code,
  output logic [CODE_W-1:0] cp_level,
  output logic [NDIV_W-1:0] n_div,
  output logic [CODE_W-1:0] rst_dly,
  output logic [TEST_W-1:0] test_bits,
  output logic [CTRL_W-1:0] ctrl_bits
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  // Pin bundle order: {enable, clock, data}; idle is enable high.
  logic [2:0] pins_raw;
  logic [2:0] pins_s;
  logic       s_clk, s_dat, s_en_n;

  assign pins_raw = {ser_en_n, ser_clk, ser_dat};

  cfg3w_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign s_en_n = pins_s[2];
  assign s_clk  = pins_s[1];
  assign s_dat  = pins_s[0];

  logic                  clk_rise;
  logic                  wr_fire;
  logic [ADDR_W-1:0]     wr_addr;
  logic [PAY_W-1:0]      wr_payload;
  logic [FRAME_BITS-1:0] sh_word;
  logic [CNT_W-1:0]      bit_cnt;

  cfg3w_frame #(.CNT_W(CNT_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_clk      (s_clk),
    .s_dat      (s_dat),
    .s_en_n     (s_en_n),
    .clk_rise   (clk_rise),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .wr_payload (wr_payload),
    .sh_word    (sh_word),
    .bit_cnt    (bit_cnt)
  );

  logic [PAY_W-1:0] bank_hi, bank_lo, bank_div, bank_cfg;

  cfg3w_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .wr_payload (wr_payload),
    .bank_hi    (bank_hi),
    .bank_lo    (bank_lo),
    .bank_div   (bank_div),
    .bank_cfg   (bank_cfg),
    .frac_q     (frac_word)
  );

  divide_t div_f;
  config_t cfg_f;

  assign div_f = divide_t'(bank_div);
  assign cfg_f = config_t'(bank_cfg);

  assign frac_hi    = bank_hi;
  assign frac_lo    = bank_lo;
  assign ref_code   = div_f.ref_code;
  assign bleed_code = div_f.bleed;
  assign cp_level   = div_f.cp;
  assign n_div      = div_f.n;
  assign rst_dly    = cfg_f.dly;
  assign test_bits  = cfg_f.test;
  assign ctrl_bits  = cfg_f.ctrl;

endmodule

// File: rtl/cfg3w_chk.sv
module cfg3w_chk
  import cfg3w_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  s_en_n,
  input logic                  clk_rise,
  input logic                  wr_fire,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [PAY_W-1:0]      wr_payload,
  input logic [FRAME_BITS-1:0] sh_word,
  input logic [CNT_W-1:0]      bit_cnt,
  input logic [PAY_W-1:0]      bank_hi,
  input logic [PAY_W-1:0]      bank_lo,
  input logic [PAY_W-1:0]      bank_div,
  input logic [PAY_W-1:0]      bank_cfg,
  input logic [FRAC_W-1:0]     frac_word
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);

  // R2
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_en_n |=> $stable(sh_word));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_en_n && clk_rise && bit_cnt != CNT_MAX) |=> bit_cnt == $past(bit_cnt) + CNT_W'(1));

  // R7
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_MAX);

  // R7
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable({bank_hi, bank_lo, bank_div, bank_cfg}));

  // R4
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == 2'd0) |=> bank_hi == $past(wr_payload));

  // R5
  div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == 2'd2) |=> bank_div == $past(wr_payload));

  // R6
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == 2'd3) |=> bank_cfg == $past(wr_payload));

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && wr_addr == 2'd1) |=> $stable(frac_word));

  // R8
  word_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == 2'd1) |=> frac_word == {$past(bank_hi), $past(wr_payload)});

endmodule

bind serial_cfg_slave cfg3w_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_en_n     (s_en_n),
  .clk_rise   (clk_rise),
  .wr_fire    (wr_fire),
  .wr_addr    (wr_addr),
  .wr_payload (wr_payload),
  .sh_word    (sh_word),
  .bit_cnt    (bit_cnt),
  .bank_hi    (bank_hi),
  .bank_lo    (bank_lo),
  .bank_div   (bank_div),
  .bank_cfg   (bank_cfg),
  .frac_word  (frac_word)
);

// File: tb/tb_serial_cfg_slave.sv
module tb_serial_cfg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int TB_SYNC    = 3;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ser_en_n = 1'b1;

  logic [27:0] frac_word;
  logic [13:0] frac_hi, frac_lo;
  logic [1:0]  ref_code, bleed_code, cp_level, rst_dly;
  logic [7:0]  n_div;
  logic [5:0]  test_bits, ctrl_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_slave #(.SYNC_STAGES(TB_SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
    .frac_word(frac_word), .frac_hi(frac_hi), .frac_lo(frac_lo),
    .ref_code(ref_code), .bleed_code(bleed_code), .cp_level(cp_level), .n_div(n_div),
    .rst_dly(rst_dly), .test_bits(test_bits), .ctrl_bits(ctrl_bits)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(string tag, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural model ----------------
  bit qc[$], qd[$], qe[$];
  int m_hi, m_lo, m_div, m_cfg, m_cnt;
  longint m_word;
  int m_sh;

  task automatic model_reset();
    qc.delete(); qd.delete(); qe.delete();
    for (int i = 0; i <= TB_SYNC; i++) begin
      qc.push_back(0); qd.push_back(0); qe.push_back(1);
    end
    m_hi = 8192; m_lo = 0; m_word = longint'(8192) * 16384;
    m_div = (3 << 8) + 177; m_cfg = 15; m_cnt = 0; m_sh = 0;
  endtask

  task automatic model_commit(int word);
    int a, p;
    a = word % 4;
    p = word / 4;
    case (a)
      0: m_hi = p;
      1: begin m_lo = p; m_word = longint'(m_hi) * 16384 + p; end
      2: m_div = p;
      default: m_cfg = p;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit cc, pc, cd, ce, pe;
      qc.push_back(ser_clk); qd.push_back(ser_dat); qe.push_back(ser_en_n);
      cc = qc[1]; pc = qc[0]; cd = qd[1]; ce = qe[1]; pe = qe[0];
      void'(qc.pop_front()); void'(qd.pop_front()); void'(qe.pop_front());
      if (ce && !pe && m_cnt == 16) model_commit(m_sh);
      if (ce) m_cnt = 0;
      else if (cc && !pc) begin
        m_sh = (m_sh * 2 + int'(cd)) % 65536;
        if (m_cnt < 17) m_cnt++;
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!done && qc.size() != 0) begin
      check("R4 frac_hi", frac_hi, m_hi);
      check("R4 frac_lo", frac_lo, m_lo);
      check("R8 frac_word", frac_word, m_word);
      check("R5 ref_code", ref_code, (m_div / 4096) % 4);
      check("R5 bleed_code", bleed_code, (m_div / 1024) % 4);
      check("R5 cp_level", cp_level, (m_div / 256) % 4);
      check("R5 n_div", n_div, m_div % 256);
      check("R6 rst_dly", rst_dly, (m_cfg / 4096) % 4);
      check("R6 test_bits", test_bits, (m_cfg / 64) % 64);
      check("R6 ctrl_bits", ctrl_bits, m_cfg % 64);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_bits(longint v, int nbits);
    @(negedge clk) ser_en_n = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = v[i];
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic raise_en();
    @(negedge clk) ser_en_n = 1'b1;
    repeat (TB_SYNC + 4) @(negedge clk);
  endtask

  task automatic write_reg(int addr, int payload);
    send_bits(longint'(payload) * 4 + addr, 16);
    raise_en();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset values
    check("R1 frac_hi", frac_hi, 8192);
    check("R1 frac_lo", frac_lo, 0);
    check("R1 frac_word", frac_word, longint'(8192) * 16384);
    check("R1 cp_level", cp_level, 3);
    check("R1 n_div", n_div, 177);
    check("R1 ref/bleed", {ref_code, bleed_code}, 0);
    check("R1 rst_dly/test", {rst_dly, test_bits}, 0);
    check("R1 ctrl_bits", ctrl_bits, 15);

    // R2: serial clocks while the enable is high are ignored
    ser_dat = 1'b1;
    for (int i = 0; i < 20; i++) begin
      repeat (HALF) @(negedge clk) ser_clk = 1'b1;
      repeat (HALF) @(negedge clk) ser_clk = 1'b0;
    end
    repeat (TB_SYNC + 4) @(negedge clk);
    check("R2 n_div after idle clocks", n_div, 177);
    check("R2 ctrl after idle clocks", ctrl_bits, 15);

    // R3/R5: divide register, ref=2 bleed=1 cp=0 n=200
    write_reg(2, (2 << 12) | (1 << 10) | (0 << 8) | 200);
    check("R3 R5 ref_code", ref_code, 2);
    check("R5 bleed_code", bleed_code, 1);
    check("R5 cp_level", cp_level, 0);
    check("R5 n_div", n_div, 200);

    // R4/R8: upper half alone leaves the joined word
    write_reg(0, 'h1234);
    check("R4 frac_hi", frac_hi, 'h1234);
    check("R8 word held after hi write", frac_word, longint'(8192) * 16384);

    write_reg(1, 'h0ABC);
    check("R4 frac_lo", frac_lo, 'h0ABC);
    check("R8 word joined", frac_word, longint'('h1234) * 16384 + 'h0ABC);

    // R6: config register, dly=3 test=0x2A ctrl=0x21
    write_reg(3, (3 << 12) | ('h2A << 6) | 'h21);
    check("R6 rst_dly", rst_dly, 3);
    check("R6 test_bits", test_bits, 'h2A);
    check("R6 ctrl_bits", ctrl_bits, 'h21);

    // R7: short frame (15 bits)
    send_bits(longint'(5) * 4 + 2, 15);
    raise_en();
    check("R7 short frame n_div", n_div, 200);
    check("R7 short frame frac_hi", frac_hi, 'h1234);

    // R7: long frame (17 bits)
    send_bits(longint'(1) * 65536 + longint'(7) * 4 + 2, 17);
    raise_en();
    check("R7 long frame n_div", n_div, 200);
    check("R7 long frame cp_level", cp_level, 0);

    // R9: commit latency in system clocks
    send_bits(longint'(99) * 4 + 2, 16);
    @(negedge clk) ser_en_n = 1'b1;
    repeat (TB_SYNC) @(posedge clk);
    @(negedge clk);
    check("R9 before latency", n_div, 200);
    @(posedge clk);
    @(negedge clk);
    check("R9 after latency", n_div, 99);
    repeat (TB_SYNC + 4) @(negedge clk);

    // R8: a second pair of fraction writes
    write_reg(0, 'h3FFF);
    check("R8 word held second", frac_word, longint'('h1234) * 16384 + 'h0ABC);
    write_reg(1, 'h0001);
    check("R8 word second join", frac_word, longint'('h3FFF) * 16384 + 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule